// File: doc/BRIEF.md
# ATA PIO Register Access Engine

This block lets a host processor reach the taskfile and control registers of devices on up to four parallel ATA buses, one 16-bit access at a time. The host hands over a single command word that packs the register address, both chip-select bits, the bus number, the transfer direction and the write data. The engine then runs one bus cycle. Address, chip selects and bus number are presented first, then an active-low read or write strobe, then a hold interval. The length of each interval is a clock count that the host programs.

During an access the engine raises a busy flag. When the access is done, a read leaves its 16-bit result on the read-data output together with a valid flag. Command words that arrive while busy is set are discarded, and a sticky error flag records each discard. A configuration input carries a global enable, a drive level for the device reset pin, and the three interval lengths. Each bus has an interrupt input that latches into a pending bit. A per-bus mask gates the pending bits onto a combined interrupt, and writing an acknowledge vector clears them.

Top module: `ata_pio_engine`

## Requirements
- R1: Command word layout (for the default of four buses):
  - bits 15:0 hold the write data;
  - bits 18:16 hold the register address;
  - bit 19 is chip select 0 and bit 20 is chip select 1;
  - bits 22:21 hold the bus number;
  - bit 23 is 1 for a read and 0 for a write.
  
  A command word written while the engine is idle and enabled raises `busy` at the next clock. `tx_ready` is 1 only while the engine is enabled and idle.
- R2: An access keeps `busy` high for exactly setup + strobe + hold cycles. The strobe goes low only after the setup cycles have passed. A setup or hold count of zero skips that phase.
- R3: A programmed strobe count of zero produces a strobe one cycle wide.
- R4: During a write, `ata_wr_n` is low for the strobe cycles and `ata_rd_n` stays high. `ata_dout_en` is high and `ata_dout` equals the write data for every busy cycle.
- R5: During a read, `ata_rd_n` is low for the strobe cycles, `ata_wr_n` stays high and `ata_dout_en` stays low. `ata_din` is sampled on the last strobe cycle. That value then appears on `rd_data` with `data_valid` set, and `data_valid` clears when the next command word is accepted.
- R6: A command word written while `busy` is high changes nothing on the bus outputs or in the access timing, and it sets `drop_err`, which stays set until reset.
- R7: A command word written while the enable bit is clear is ignored: `busy` stays low and `drop_err` stays clear.
- R8: `ata_addr` and `ata_bus` carry the command's address and bus number during the access. `ata_cs0_n` and `ata_cs1_n` are the inverted chip-select bits while busy and are both high while idle.
- R9: A high `bus_irq` bit sets the matching pending bit. Writing an acknowledge vector clears each pending bit whose position holds a one. `irq` is high when any pending bit has its mask bit set.
- R10: `ata_reset_n` is low exactly while the device-reset configuration bit is 1.
- R11: After reset, the following outputs are low: `busy`, `data_valid`, `drop_err`, `irq`, `tx_ready` and `ata_dout_en`. Both strobes, both chip selects and `ata_reset_n` are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_we | input | 1 | Command word strobe |
| cmd_word | input | 24 | Command word (layout in R1) |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_enable | input | 1 | Global enable |
| cfg_dev_reset | input | 1 | 1 drives the device reset pin active |
| cfg_setup | input | 8 | Setup phase length in cycles |
| cfg_strobe | input | 8 | Strobe phase length in cycles (0 acts as 1) |
| cfg_hold | input | 8 | Hold phase length in cycles |
| mask_we | input | 1 | Interrupt mask write strobe |
| mask_val | input | 4 | Interrupt mask, one bit per bus |
| ack_we | input | 1 | Interrupt acknowledge strobe |
| ack_val | input | 4 | Acknowledge vector, one bit per bus |
| bus_irq | input | 4 | Interrupt request from each bus |
| busy | output | 1 | Access in progress |
| tx_ready | output | 1 | Enabled and idle |
| data_valid | output | 1 | Read data valid |
| rd_data | output | 16 | Last read value |
| drop_err | output | 1 | Sticky flag for a command dropped while busy |
| irq | output | 1 | Combined masked interrupt |
| irq_pending | output | 4 | Pending interrupt bits |
| ata_addr | output | 3 | Device register address |
| ata_cs0_n | output | 1 | Chip select 0, active low |
| ata_cs1_n | output | 1 | Chip select 1, active low |
| ata_bus | output | 2 | Selected bus number |
| ata_dout | output | 16 | Write data to the bus |
| ata_dout_en | output | 1 | Write data driver enable |
| ata_din | input | 16 | Read data from the bus |
| ata_rd_n | output | 1 | Read strobe, active low |
| ata_wr_n | output | 1 | Write strobe, active low |
| ata_reset_n | output | 1 | Device reset, active low |

## Verification
A wrong phase counter shows up within the same access in two ways. The busy window is longer or shorter than the sum of the three counts, and the strobe starts at the wrong cycle. Either one is visible on the pins before the access ends.

A read capture taken in the wrong cycle returns a wrong value. The bench drives the correct data only on the last strobe cycle, so the error appears on `rd_data` as soon as `busy` falls.

A failed guard against commands issued while busy shows at once on the next clock. The address or output-enable changes in the middle of the access, or the access timing is disturbed.

// File: rtl/ata_pio_engine.sv
module ata_pio_engine #(
  parameter int NBUS      = 4,
  parameter int CNT_W     = 8,
  parameter int RST_SETUP = 9,
  parameter int RST_STRB  = 39,
  parameter int RST_HOLD  = 9,
  localparam int BSEL_W   = $clog2(NBUS),
  localparam int CMD_W    = 22 + BSEL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_we,
  input  logic [CMD_W-1:0]  cmd_word,
  input  logic              cfg_we,
  input  logic              cfg_enable,
  input  logic              cfg_dev_reset,
  input  logic [CNT_W-1:0]  cfg_setup,
  input  logic [CNT_W-1:0]  cfg_strobe,
  input  logic [CNT_W-1:0]  cfg_hold,
  input  logic              mask_we,
  input  logic [NBUS-1:0]   mask_val,
  input  logic              ack_we,
  input  logic [NBUS-1:0]   ack_val,
  input  logic [NBUS-1:0]   bus_irq,
  output logic              busy,
  output logic              tx_ready,
  output logic              data_valid,
  output logic [15:0]       rd_data,
  output logic              drop_err,
  output logic              irq,
  output logic [NBUS-1:0]   irq_pending,
  output logic [2:0]        ata_addr,
  output logic              ata_cs0_n,
  output logic              ata_cs1_n,
  output logic [BSEL_W-1:0] ata_bus,
  output logic [15:0]       ata_dout,
  output logic              ata_dout_en,
  input  logic [15:0]       ata_din,
  output logic              ata_rd_n,
  output logic              ata_wr_n,
  output logic              ata_reset_n
);

  localparam int B_ADDR = 16;
  localparam int B_CS0  = 19;
  localparam int B_CS1  = 20;
  localparam int B_BUS  = 21;
  localparam int B_RD   = 21 + BSEL_W;

  typedef enum logic [1:0] {S_IDLE, S_SETUP, S_STRB, S_HOLD} phase_t;

  phase_t             ph;
  logic [CNT_W-1:0]   cnt;
  logic [CNT_W-1:0]   setup_r, strb_r, hold_r;
  logic               en_r, devrst_r;
  logic [NBUS-1:0]    mask_r;
  logic [15:0]        wdat_r;
  logic [2:0]         addr_r;
  logic               cs0_r, cs1_r, rd_r;
  logic [BSEL_W-1:0]  bus_r;

  wire               accept   = cmd_we && en_r && (ph == S_IDLE);
  wire [CNT_W-1:0]   strb_m1  = (strb_r == '0) ? '0 : strb_r - 1'b1;
  wire               strb_end = (ph == S_STRB) && (cnt == '0);

  assign busy        = (ph != S_IDLE);
  assign tx_ready    = en_r && !busy;
  assign ata_addr    = addr_r;
  assign ata_bus     = bus_r;
  assign ata_cs0_n   = !(busy && cs0_r);
  assign ata_cs1_n   = !(busy && cs1_r);
  assign ata_dout    = wdat_r;
  assign ata_dout_en = busy && !rd_r;
  assign ata_rd_n    = !((ph == S_STRB) && rd_r);
  assign ata_wr_n    = !((ph == S_STRB) && !rd_r);
  assign ata_reset_n = !devrst_r;
  assign irq         = |(irq_pending & mask_r);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_r     <= 1'b0;
      devrst_r <= 1'b0;
      setup_r  <= CNT_W'(RST_SETUP);
      strb_r   <= CNT_W'(RST_STRB);
      hold_r   <= CNT_W'(RST_HOLD);
      mask_r   <= '0;
    end else begin
      if (cfg_we) begin
        en_r     <= cfg_enable;
        devrst_r <= cfg_dev_reset;
        setup_r  <= cfg_setup;
        strb_r   <= cfg_strobe;
        hold_r   <= cfg_hold;
      end
      if (mask_we) mask_r <= mask_val;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_pending <= '0;
    else        irq_pending <= (irq_pending & ~(ack_we ? ack_val : '0)) | bus_irq;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wdat_r <= '0;
      addr_r <= '0;
      cs0_r  <= 1'b0;
      cs1_r  <= 1'b0;
      bus_r  <= '0;
      rd_r   <= 1'b0;
    end else if (accept) begin
      wdat_r <= cmd_word[15:0];
      addr_r <= cmd_word[B_ADDR +: 3];
      cs0_r  <= cmd_word[B_CS0];
      cs1_r  <= cmd_word[B_CS1];
      bus_r  <= cmd_word[B_BUS +: BSEL_W];
      rd_r   <= cmd_word[B_RD];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph  <= S_IDLE;
      cnt <= '0;
    end else begin
      unique case (ph)
        S_IDLE: if (accept) begin
          if (setup_r != '0) begin ph <= S_SETUP; cnt <= setup_r - 1'b1; end
          else               begin ph <= S_STRB;  cnt <= strb_m1;        end
        end
        S_SETUP: if (cnt == '0) begin ph <= S_STRB; cnt <= strb_m1; end
                 else cnt <= cnt - 1'b1;
        S_STRB: if (cnt == '0) begin
          if (hold_r != '0) begin ph <= S_HOLD; cnt <= hold_r - 1'b1; end
          else              ph <= S_IDLE;
        end else cnt <= cnt - 1'b1;
        S_HOLD: if (cnt == '0) ph <= S_IDLE;
                else cnt <= cnt - 1'b1;
        default: ph <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data    <= '0;
      data_valid <= 1'b0;
      drop_err   <= 1'b0;
    end else begin
      if (accept) data_valid <= 1'b0;
      else if (strb_end && rd_r) begin
        rd_data    <= ata_din;
        data_valid <= 1'b1;
      end
      if (cmd_we && busy) drop_err <= 1'b1;
    end
  end

  // R4 / R5: never both strobes at once
  a_r4_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !(!ata_rd_n && !ata_wr_n));

  a_r2_strobe_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (!ata_rd_n || !ata_wr_n) |-> busy);

  a_r6_drop_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_we && busy) |=> drop_err);

  a_r6_addr_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(ata_addr) && $stable(ata_dout_en));

  a_r8_cs_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (ata_cs0_n && ata_cs1_n));

  a_r5_valid_clears: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !data_valid);

  a_r7_disabled_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_r && !busy) |=> !busy);

endmodule

// File: tb/ata_pio_engine_tb_top.sv
`timescale 1ns/1ps
module ata_pio_engine_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_we = 1'b0;
  logic [23:0] cmd_word = '0;
  logic cfg_we = 1'b0, cfg_enable = 1'b0, cfg_dev_reset = 1'b0;
  logic [7:0] cfg_setup = '0, cfg_strobe = '0, cfg_hold = '0;
  logic mask_we = 1'b0, ack_we = 1'b0;
  logic [3:0] mask_val = '0, ack_val = '0, bus_irq = '0;
  logic busy, tx_ready, data_valid, drop_err, irq;
  logic [15:0] rd_data, ata_dout;
  logic [15:0] ata_din = '0;
  logic [3:0] irq_pending;
  logic [2:0] ata_addr;
  logic [1:0] ata_bus;
  logic ata_cs0_n, ata_cs1_n, ata_dout_en, ata_rd_n, ata_wr_n, ata_reset_n;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  ata_pio_engine dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .cmd_word(cmd_word),
    .cfg_we(cfg_we), .cfg_enable(cfg_enable), .cfg_dev_reset(cfg_dev_reset),
    .cfg_setup(cfg_setup), .cfg_strobe(cfg_strobe), .cfg_hold(cfg_hold),
    .mask_we(mask_we), .mask_val(mask_val), .ack_we(ack_we), .ack_val(ack_val),
    .bus_irq(bus_irq), .busy(busy), .tx_ready(tx_ready), .data_valid(data_valid),
    .rd_data(rd_data), .drop_err(drop_err), .irq(irq), .irq_pending(irq_pending),
    .ata_addr(ata_addr), .ata_cs0_n(ata_cs0_n), .ata_cs1_n(ata_cs1_n),
    .ata_bus(ata_bus), .ata_dout(ata_dout), .ata_dout_en(ata_dout_en),
    .ata_din(ata_din), .ata_rd_n(ata_rd_n), .ata_wr_n(ata_wr_n),
    .ata_reset_n(ata_reset_n)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // rd, addr, cs0, cs1, bus, wdata, setup, strobe, hold, din
  localparam int NV = 6;
  localparam logic [63:0] VEC [0:NV-1] = '{
    {1'b0, 3'd7, 1'b1, 1'b0, 2'd0, 16'hA5C3, 8'd3, 8'd7,  8'd1, 16'h0000},
    {1'b1, 3'd7, 1'b1, 1'b0, 2'd1, 16'h0000, 8'd9, 8'd39, 8'd9, 16'h1234},
    {1'b0, 3'd6, 1'b0, 1'b1, 2'd2, 16'h0004, 8'd2, 8'd0,  8'd0, 16'h0000},
    {1'b1, 3'd0, 1'b1, 1'b0, 2'd3, 16'h0000, 8'd0, 8'd1,  8'd0, 16'hBEEF},
    {1'b1, 3'd3, 1'b1, 1'b0, 2'd2, 16'h0000, 8'd1, 8'd3,  8'd2, 16'h00FF},
    {1'b0, 3'd5, 1'b1, 1'b0, 2'd1, 16'hFFFF, 8'd0, 8'd2,  8'd3, 16'h0000}
  };

  task automatic set_cfg(input bit en, input bit dr, input int s, input int t, input int h);
    @(negedge clk);
    cfg_we = 1'b1; cfg_enable = en; cfg_dev_reset = dr;
    cfg_setup = 8'(s); cfg_strobe = 8'(t); cfg_hold = 8'(h);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  function automatic logic [23:0] mk_cmd(input bit rd, input logic [2:0] a, input bit c0,
                                         input bit c1, input logic [1:0] b, input logic [15:0] d);
    return {rd, b, c1, c0, a, d};
  endfunction

  task automatic run_vec(input logic [63:0] v, input int idx);
    bit rd = v[63];
    logic [2:0] a = v[62:60];
    bit c0 = v[59];
    bit c1 = v[58];
    logic [1:0] b = v[57:56];
    logic [15:0] wd = v[55:40];
    int s = int'(v[39:32]);
    int t = int'(v[31:24]);
    int h = int'(v[23:16]);
    logic [15:0] din = v[15:0];
    int teff = (t == 0) ? 1 : t;
    int n = 0, scnt = 0, sfirst = -1, mism = 0, wrong_strb = 0;
    set_cfg(1'b1, 1'b0, s, t, h);
    chk(tx_ready == 1'b1, "R1 tx_ready idle", tx_ready, 1);
    @(negedge clk);
    cmd_word = mk_cmd(rd, a, c0, c1, b, wd); cmd_we = 1'b1;
    @(negedge clk);
    cmd_we = 1'b0;
    chk(busy == 1'b1 && tx_ready == 1'b0, "R1 busy after accept", busy, 1);
    while (busy && n < 600) begin
      if (ata_addr != a || ata_bus != b || ata_cs0_n != !c0 || ata_cs1_n != !c1) mism++;
      if (ata_dout_en != !rd || (!rd && ata_dout != wd)) mism++;
      if (!ata_rd_n || !ata_wr_n) begin
        if (sfirst < 0) sfirst = n;
        scnt++;
        if ((rd && ata_rd_n) || (!rd && ata_wr_n)) wrong_strb++;
      end
      ata_din = (!ata_rd_n && scnt == teff) ? din : ~din;
      n++;
      @(negedge clk);
    end
    chk(n == s + teff + h, $sformatf("R2 busy length vec%0d", idx), n, s + teff + h);
    chk(sfirst == s, $sformatf("R2 strobe start vec%0d", idx), sfirst, s);
    chk(scnt == teff, $sformatf("R3 strobe width vec%0d", idx), scnt, teff);
    chk(wrong_strb == 0, $sformatf("R4 R5 strobe kind vec%0d", idx), wrong_strb, 0);
    chk(mism == 0, $sformatf("R8 R4 bus fields vec%0d", idx), mism, 0);
    if (rd) begin
      chk(data_valid == 1'b1, $sformatf("R5 data_valid vec%0d", idx), data_valid, 1);
      chk(rd_data == din, $sformatf("R5 read capture vec%0d", idx), rd_data, din);
    end
    chk(ata_cs0_n && ata_cs1_n, "R8 cs idle", {ata_cs0_n, ata_cs1_n}, 3);
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    chk(!busy && !data_valid && !drop_err && !irq && !tx_ready && !ata_dout_en,
        "R11 reset flags", {busy, data_valid, drop_err, irq, tx_ready, ata_dout_en}, 0);
    chk(ata_rd_n && ata_wr_n && ata_cs0_n && ata_cs1_n && ata_reset_n,
        "R11 reset pins", {ata_rd_n, ata_wr_n, ata_cs0_n, ata_cs1_n, ata_reset_n}, 5'h1f);

    // R7 disabled engine ignores commands
    @(negedge clk);
    cmd_word = mk_cmd(1'b0, 3'd1, 1'b1, 1'b0, 2'd0, 16'h1111); cmd_we = 1'b1;
    @(negedge clk);
    cmd_we = 1'b0;
    chk(!busy && !drop_err && ata_wr_n, "R7 disabled ignore", {busy, drop_err}, 0);

    for (int i = 0; i < NV; i++) run_vec(VEC[i], i);

    // R6 command while busy dropped
    set_cfg(1'b1, 1'b0, 4, 4, 4);
    @(negedge clk);
    ata_din = 16'h5A5A;
    cmd_word = mk_cmd(1'b1, 3'd2, 1'b1, 1'b0, 2'd1, 16'h0); cmd_we = 1'b1;
    @(negedge clk);
    cmd_word = mk_cmd(1'b0, 3'd5, 1'b0, 1'b1, 2'd3, 16'hDEAD);
    begin
      int n = 1;
      @(negedge clk);
      cmd_we = 1'b0;
      chk(drop_err == 1'b1, "R6 drop_err set", drop_err, 1);
      chk(ata_addr == 3'd2 && ata_bus == 2'd1 && !ata_dout_en && !ata_cs0_n && ata_cs1_n,
          "R6 access unchanged", {ata_addr, ata_bus}, {3'd2, 2'd1});
      while (busy && n < 100) begin n++; @(negedge clk); end
      chk(n == 12, "R6 timing unchanged", n, 12);
      chk(rd_data == 16'h5A5A && data_valid, "R6 R5 read result", rd_data, 16'h5A5A);
    end

    // R5 data_valid cleared by next accepted command
    @(negedge clk);
    cmd_word = mk_cmd(1'b0, 3'd1, 1'b1, 1'b0, 2'd0, 16'h0); cmd_we = 1'b1;
    @(negedge clk);
    cmd_we = 1'b0;
    chk(data_valid == 1'b0, "R5 valid clears", data_valid, 0);
    chk(drop_err == 1'b1, "R6 drop_err sticky", drop_err, 1);
    while (busy) @(negedge clk);

    // R9 interrupts
    mask_we = 1'b1; mask_val = 4'b0101;
    @(negedge clk);
    mask_we = 1'b0; bus_irq = 4'b0010;
    @(negedge clk);
    bus_irq = 4'b0000;
    @(negedge clk);
    chk(irq_pending == 4'b0010 && !irq, "R9 masked pending", {irq_pending, irq}, 5'b00100);
    bus_irq = 4'b0100;
    @(negedge clk);
    bus_irq = 4'b0000;
    @(negedge clk);
    chk(irq_pending == 4'b0110 && irq, "R9 unmasked irq", {irq_pending, irq}, 5'b01101);
    ack_we = 1'b1; ack_val = 4'b0100;
    @(negedge clk);
    ack_we = 1'b0;
    @(negedge clk);
    chk(irq_pending == 4'b0010 && !irq, "R9 acknowledge", {irq_pending, irq}, 5'b00100);

    // R10 device reset pin
    set_cfg(1'b1, 1'b1, 1, 1, 1);
    chk(ata_reset_n == 1'b0, "R10 reset active", ata_reset_n, 0);
    set_cfg(1'b1, 1'b0, 1, 1, 1);
    chk(ata_reset_n == 1'b1, "R10 reset inactive", ata_reset_n, 1);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule